// File: doc/BRIEF.md
# Bus master security gate

This block stands between a single bus-mastering device, such as a DMA engine, and the system interconnect. It vets each read or write that the master issues. For each request it asks an external address-attribution port whether the address is exempt from checking and whether it is non-secure. From that answer and two static configuration pins, it chooses one of four outcomes:

- pass the request downstream tagged secure;
- pass it downstream tagged non-secure;
- answer it locally with zero data and an OK status;
- answer it locally with an error status.

One configuration pin marks the master as non-secure. The other selects which of the two local answers a rejection gets. Error-type rejections set a sticky level interrupt, which a clear pin removes. Only one transaction is in flight at a time. The attribution answer and the configuration pins are sampled in the cycle the request is accepted.

Top module: `bus_sec_gate`

## Requirements
- R1: For an address the lookup marks exempt, the request is forwarded downstream. `dn_req_nonsec` equals `cfg_master_ns` as sampled at acceptance.
- R2: For a non-exempt address attributed non-secure, the request is forwarded with `dn_req_nonsec`=1, for either value of `cfg_master_ns`.
- R3: For a non-exempt address attributed secure, with `cfg_master_ns`=0, the request is forwarded with `dn_req_nonsec`=0.
- R4: For a non-exempt secure address with `cfg_master_ns`=1 and `cfg_reject_err`=0, the request never reaches the downstream port. It is answered with `up_rsp_err`=0 and `up_rsp_rdata`=0, for a read or a write, and `irq` stays unchanged.
- R5: The same rejection with `cfg_reject_err`=1 is answered with `up_rsp_err`=1, and never reaches downstream. `irq` is 1 from the cycle after acceptance, unless `irq_clr` is high in the accepting cycle.
- R6: While `irq_clr` is high, `irq` is 0 from the following cycle on. A rejection accepted while `irq_clr` is high leaves `irq` at 0 after the clear drops.
- R7: Once set, `irq` stays 1 across later transactions of any kind until `irq_clr` is raised.
- R8: A forwarded request carries the master's address, write flag, size code and write data unchanged. It is held stable while `dn_req_ready` is low. The downstream read data and error flag are returned to the master unchanged.
- R9: `up_req_ready` is low from the cycle after acceptance until the response has been shown. `up_rsp_valid` is a one-cycle pulse, and `up_req_ready` returns to 1 in the cycle after it.
- R10: Changing `cfg_master_ns` or `cfg_reject_err` after a request is accepted does not change the outcome of that request.
- R11: After reset, `up_req_ready`=1, and `irq`, `dn_req_valid` and `up_rsp_valid` are 0.
- R12: Size codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. Data is little-endian: byte lane k carries the byte at the address whose low three bits equal k. Every size code and lane passes through the gate unaltered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_master_ns | input | 1 | 1: master is non-secure |
| cfg_reject_err | input | 1 | 1: rejections get error response and interrupt |
| irq_clr | input | 1 | Clears and holds clear the interrupt |
| irq | output | 1 | Sticky rejection interrupt |
| up_req_valid | input | 1 | Master request valid |
| up_req_ready | output | 1 | Gate can accept a request |
| up_req_write | input | 1 | 1: write, 0: read |
| up_req_addr | input | ADDR_W | Request address |
| up_req_size | input | 2 | Access size code |
| up_req_wdata | input | DATA_W | Write data |
| up_rsp_valid | output | 1 | Response pulse to master |
| up_rsp_rdata | output | DATA_W | Read data to master |
| up_rsp_err | output | 1 | Error status to master |
| attr_addr | output | ADDR_W | Address presented to attribution lookup |
| attr_exempt | input | 1 | Lookup: address exempt from checking |
| attr_nonsec | input | 1 | Lookup: address non-secure |
| dn_req_valid | output | 1 | Downstream request valid |
| dn_req_ready | input | 1 | Downstream accepts request |
| dn_req_write | output | 1 | Downstream write flag |
| dn_req_addr | output | ADDR_W | Downstream address |
| dn_req_size | output | 2 | Downstream size code |
| dn_req_wdata | output | DATA_W | Downstream write data |
| dn_req_nonsec | output | 1 | Security tag: 1 non-secure, 0 secure |
| dn_rsp_valid | input | 1 | Downstream response valid |
| dn_rsp_rdata | input | DATA_W | Downstream read data |
| dn_rsp_err | input | 1 | Downstream error status |

## Verification
Interrupt setting and interrupt clearing can fall in the same cycle. This happens when an error-type rejection is accepted while `irq_clr` is held high. The bench provokes it by raising the clear, issuing a rejected secure access from a non-secure master, and then dropping the clear. The clear must win: the master still sees the error response, but `irq` must read 0 both during the clear and after it drops.

// File: rtl/bsg_pkg.sv
package bsg_pkg;

    // Outcome of a security check on one request
    typedef enum logic [1:0] {
        ACT_FWD_SEC  = 2'd0,
        ACT_FWD_NS   = 2'd1,
        ACT_BLK_ZERO = 2'd2,
        ACT_BLK_ERR  = 2'd3
    } bsg_action_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DNREQ = 2'd1,
        ST_WAIT = 2'd2,
        ST_RESP = 2'd3
    } bsg_state_e;

    // Attribution answer for one address
    typedef struct packed {
        logic exempt;
        logic nonsec;
    } bsg_attr_t;

    // Security configuration sampled at acceptance
    typedef struct packed {
        logic master_ns;
        logic reject_err;
    } bsg_cfg_t;

    function automatic bsg_action_e bsg_decide(bsg_attr_t a, bsg_cfg_t c);
        if (a.exempt)
            return c.master_ns ? ACT_FWD_NS : ACT_FWD_SEC;
        if (a.nonsec)
            return ACT_FWD_NS;
        if (!c.master_ns)
            return ACT_FWD_SEC;
        return c.reject_err ? ACT_BLK_ERR : ACT_BLK_ZERO;
    endfunction

    function automatic logic bsg_is_block(bsg_action_e a);
        return (a == ACT_BLK_ZERO) || (a == ACT_BLK_ERR);
    endfunction

endpackage

// File: rtl/bsg_classify.sv
module bsg_classify
    import bsg_pkg::*;
(
    input  bsg_attr_t   attr_i,
    input  bsg_cfg_t    cfg_i,
    output bsg_action_e action_o
);
    always_comb action_o = bsg_decide(attr_i, cfg_i);
endmodule

// File: rtl/bsg_irq_status.sv
module bsg_irq_status (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic irq_o
);
    logic status_q;

    always_ff @(posedge clk) begin
        if (rst)        status_q <= 1'b0;
        else if (clr_i) status_q <= 1'b0;
        else if (set_i) status_q <= 1'b1;
    end

    assign irq_o = status_q;

    assert_clear_wins_R6: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> !irq_o);
    assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (irq_o && !clr_i) |=> irq_o);
    assert_set_source_R5: assert property (@(posedge clk) disable iff (rst)
        (!irq_o && !set_i) |=> !irq_o);
endmodule

// File: rtl/bsg_txn_ctrl.sv
module bsg_txn_ctrl
    import bsg_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              up_req_valid,
    output logic              up_req_ready,
    input  logic              up_req_write,
    input  logic [ADDR_W-1:0] up_req_addr,
    input  logic [1:0]        up_req_size,
    input  logic [DATA_W-1:0] up_req_wdata,
    output logic              up_rsp_valid,
    output logic [DATA_W-1:0] up_rsp_rdata,
    output logic              up_rsp_err,
    input  bsg_action_e       action_i,
    output logic              irq_set_o,
    output logic              dn_req_valid,
    input  logic              dn_req_ready,
    output logic              dn_req_write,
    output logic [ADDR_W-1:0] dn_req_addr,
    output logic [1:0]        dn_req_size,
    output logic [DATA_W-1:0] dn_req_wdata,
    output logic              dn_req_nonsec,
    input  logic              dn_rsp_valid,
    input  logic [DATA_W-1:0] dn_rsp_rdata,
    input  logic              dn_rsp_err
);
    bsg_state_e        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic [1:0]        size_q;
    logic              write_q, ns_q, err_q;
    logic              accept;

    assign up_req_ready = (state_q == ST_IDLE);
    assign accept       = up_req_valid && up_req_ready;
    assign irq_set_o    = accept && (action_i == ACT_BLK_ERR);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            size_q  <= '0;
            write_q <= 1'b0;
            ns_q    <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    addr_q  <= up_req_addr;
                    wdata_q <= up_req_wdata;
                    size_q  <= up_req_size;
                    write_q <= up_req_write;
                    ns_q    <= (action_i == ACT_FWD_NS);
                    rdata_q <= '0;
                    err_q   <= (action_i == ACT_BLK_ERR);
                    state_q <= bsg_is_block(action_i) ? ST_RESP : ST_DNREQ;
                end
                ST_DNREQ: if (dn_req_ready) state_q <= ST_WAIT;
                ST_WAIT: if (dn_rsp_valid) begin
                    rdata_q <= dn_rsp_rdata;
                    err_q   <= dn_rsp_err;
                    state_q <= ST_RESP;
                end
                ST_RESP: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign dn_req_valid  = (state_q == ST_DNREQ);
    assign dn_req_write  = write_q;
    assign dn_req_addr   = addr_q;
    assign dn_req_size   = size_q;
    assign dn_req_wdata  = wdata_q;
    assign dn_req_nonsec = ns_q;
    assign up_rsp_valid  = (state_q == ST_RESP);
    assign up_rsp_rdata  = rdata_q;
    assign up_rsp_err    = err_q;

    assert_single_outstanding_R9: assert property (@(posedge clk) disable iff (rst)
        accept |=> !up_req_ready);
    assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        up_rsp_valid |=> (!up_rsp_valid && up_req_ready));
    assert_dn_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (dn_req_valid && !dn_req_ready) |=>
            (dn_req_valid && $stable(dn_req_addr) && $stable(dn_req_wdata)));
    assert_blocked_local_R4: assert property (@(posedge clk) disable iff (rst)
        (accept && bsg_is_block(action_i)) |=> (up_rsp_valid && !dn_req_valid));
endmodule

// File: rtl/bus_sec_gate.sv
module bus_sec_gate
    import bsg_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_master_ns,
    input  logic              cfg_reject_err,
    input  logic              irq_clr,
    output logic              irq,
    input  logic              up_req_valid,
    output logic              up_req_ready,
    input  logic              up_req_write,
    input  logic [ADDR_W-1:0] up_req_addr,
    input  logic [1:0]        up_req_size,
    input  logic [DATA_W-1:0] up_req_wdata,
    output logic              up_rsp_valid,
    output logic [DATA_W-1:0] up_rsp_rdata,
    output logic              up_rsp_err,
    output logic [ADDR_W-1:0] attr_addr,
    input  logic              attr_exempt,
    input  logic              attr_nonsec,
    output logic              dn_req_valid,
    input  logic              dn_req_ready,
    output logic              dn_req_write,
    output logic [ADDR_W-1:0] dn_req_addr,
    output logic [1:0]        dn_req_size,
    output logic [DATA_W-1:0] dn_req_wdata,
    output logic              dn_req_nonsec,
    input  logic              dn_rsp_valid,
    input  logic [DATA_W-1:0] dn_rsp_rdata,
    input  logic              dn_rsp_err
);
    bsg_attr_t   attr;
    bsg_cfg_t    cfg;
    bsg_action_e action;
    logic        irq_set;

    assign attr_addr = up_req_addr;
    assign attr = '{exempt: attr_exempt, nonsec: attr_nonsec};
    assign cfg  = '{master_ns: cfg_master_ns, reject_err: cfg_reject_err};

    bsg_classify u_classify (
        .attr_i   (attr),
        .cfg_i    (cfg),
        .action_o (action)
    );

    bsg_txn_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .up_req_valid (up_req_valid),
        .up_req_ready (up_req_ready),
        .up_req_write (up_req_write),
        .up_req_addr  (up_req_addr),
        .up_req_size  (up_req_size),
        .up_req_wdata (up_req_wdata),
        .up_rsp_valid (up_rsp_valid),
        .up_rsp_rdata (up_rsp_rdata),
        .up_rsp_err   (up_rsp_err),
        .action_i     (action),
        .irq_set_o    (irq_set),
        .dn_req_valid (dn_req_valid),
        .dn_req_ready (dn_req_ready),
        .dn_req_write (dn_req_write),
        .dn_req_addr  (dn_req_addr),
        .dn_req_size  (dn_req_size),
        .dn_req_wdata (dn_req_wdata),
        .dn_req_nonsec(dn_req_nonsec),
        .dn_rsp_valid (dn_rsp_valid),
        .dn_rsp_rdata (dn_rsp_rdata),
        .dn_rsp_err   (dn_rsp_err)
    );

    bsg_irq_status u_irq (
        .clk   (clk),
        .rst   (rst),
        .set_i (irq_set),
        .clr_i (irq_clr),
        .irq_o (irq)
    );
endmodule

// File: tb/test_bus_sec_gate.sv
`timescale 1ns/1ps
module test_bus_sec_gate;
    localparam int AW = 32;
    localparam int DW = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_master_ns = 1'b0, cfg_reject_err = 1'b0, irq_clr = 1'b0;
    logic irq;
    logic up_req_valid = 1'b0, up_req_ready, up_req_write = 1'b0;
    logic [AW-1:0] up_req_addr = '0;
    logic [1:0] up_req_size = '0;
    logic [DW-1:0] up_req_wdata = '0;
    logic up_rsp_valid, up_rsp_err;
    logic [DW-1:0] up_rsp_rdata;
    logic [AW-1:0] attr_addr;
    logic attr_exempt, attr_nonsec;
    logic dn_req_valid, dn_req_ready = 1'b0, dn_req_write, dn_req_nonsec;
    logic [AW-1:0] dn_req_addr;
    logic [1:0] dn_req_size;
    logic [DW-1:0] dn_req_wdata;
    logic dn_rsp_valid = 1'b0, dn_rsp_err = 1'b0;
    logic [DW-1:0] dn_rsp_rdata = '0;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    // Attribution model: 0xE... exempt, top nibble below 8 non-secure
    assign attr_exempt = (attr_addr[31:28] == 4'hE);
    assign attr_nonsec = (attr_addr[31:28] < 4'h8);

    bus_sec_gate #(.ADDR_W(AW), .DATA_W(DW)) i_bus_sec_gate (.*);

    typedef struct {
        logic [DW-1:0] rdata;
        logic err;
    } rsp_exp_t;
    typedef struct {
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [1:0] size;
        logic write;
        logic ns;
        string tag;
    } dn_exp_t;

    rsp_exp_t rsp_q[$];
    dn_exp_t  dn_q[$];
    string    rsp_tag_q[$];

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] dn_data(input logic [AW-1:0] a);
        return {~a, a};
    endfunction

    // Driver: issue one request, push expectations, wait for completion
    task automatic send(input logic wr, input logic [AW-1:0] a, input logic [1:0] sz,
                        input logic [DW-1:0] wd, input string tag);
        logic ex, ns, fwd, tag_ns;
        rsp_exp_t r;
        dn_exp_t d;
        @(negedge clk);
        up_req_valid = 1'b1; up_req_write = wr; up_req_addr = a;
        up_req_size = sz; up_req_wdata = wd;
        while (!up_req_ready) @(negedge clk);
        ex = (a[31:28] == 4'hE);
        ns = (a[31:28] < 4'h8);
        fwd = 1'b1; tag_ns = 1'b0;
        if (ex) tag_ns = cfg_master_ns;
        else if (ns) tag_ns = 1'b1;
        else if (!cfg_master_ns) tag_ns = 1'b0;
        else fwd = 1'b0;
        if (fwd) begin
            d.addr = a; d.wdata = wd; d.size = sz; d.write = wr; d.ns = tag_ns; d.tag = tag;
            dn_q.push_back(d);
            r.rdata = dn_data(a); r.err = a[4];
        end else begin
            r.rdata = '0; r.err = cfg_reject_err;
        end
        rsp_q.push_back(r);
        rsp_tag_q.push_back(tag);
        @(negedge clk);
        up_req_valid = 1'b0;
        check("R9 ready low after accept", up_req_ready, 1'b0);
        while (rsp_q.size() != 0) @(negedge clk);
        check("R9 ready back after response", up_req_ready, 1'b1);
    endtask

    // Monitor: compare master responses against the scoreboard
    always @(negedge clk) begin
        if (!rst && up_rsp_valid) begin
            if (rsp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R9 unexpected response: actual 1 expected 0");
            end else begin
                rsp_exp_t e;
                string t;
                e = rsp_q.pop_front();
                t = rsp_tag_q.pop_front();
                check({t, " rdata"}, up_rsp_rdata, e.rdata);
                check({t, " err"}, up_rsp_err, e.err);
            end
        end
    end

    // Downstream responder with alternating accept stall
    initial begin
        bit stall = 0;
        forever begin
            @(negedge clk);
            if (!rst && dn_req_valid) begin
                dn_exp_t e;
                logic [AW-1:0] a;
                if (dn_q.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R4 blocked request reached downstream: actual 1 expected 0");
                    a = dn_req_addr;
                end else begin
                    e = dn_q.pop_front();
                    check({e.tag, " dn addr"}, dn_req_addr, e.addr);
                    check({e.tag, " dn nonsec tag"}, dn_req_nonsec, e.ns);
                    check("R8 dn write", dn_req_write, e.write);
                    check("R12 dn size", dn_req_size, e.size);
                    check("R12 dn wdata lanes", dn_req_wdata, e.wdata);
                    a = e.addr;
                end
                if (stall) @(negedge clk);
                stall = !stall;
                dn_req_ready = 1'b1;
                @(negedge clk);
                dn_req_ready = 1'b0;
                @(negedge clk);
                dn_rsp_valid = 1'b1; dn_rsp_rdata = dn_data(a); dn_rsp_err = a[4];
                @(negedge clk);
                dn_rsp_valid = 1'b0;
            end
        end
    end

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R11 ready", up_req_ready, 1'b1);
        check("R11 irq", irq, 1'b0);
        check("R11 dn valid", dn_req_valid, 1'b0);
        check("R11 rsp valid", up_rsp_valid, 1'b0);

        // Secure master
        cfg_master_ns = 1'b0; cfg_reject_err = 1'b1;
        send(1'b0, 32'hE000_0020, 2'd3, '0, "R1 exempt secure master");
        send(1'b1, 32'h0000_1000, 2'd2, 64'h0807_0605_0403_0201, "R2 ns addr secure master");
        send(1'b0, 32'h9000_0020, 2'd0, '0, "R3 secure addr secure master");
        check("R3 no irq", irq, 1'b0);

        // Non-secure master
        cfg_master_ns = 1'b1; cfg_reject_err = 1'b0;
        send(1'b1, 32'hE000_0040, 2'd1, 64'h0000_0000_0000_BEEF, "R1 exempt ns master");
        send(1'b0, 32'h1000_0008, 2'd3, '0, "R2 ns addr ns master");
        send(1'b0, 32'h9000_0100, 2'd2, '0, "R4 silent reject read");
        send(1'b1, 32'hA000_0000, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, "R4 silent reject write");
        check("R4 no irq", irq, 1'b0);

        // Downstream error passthrough and size codes
        send(1'b0, 32'h2000_0010, 2'd0, '0, "R8 downstream error");
        for (int s = 0; s < 4; s++)
            send(1'b1, 32'h3000_0000 + 32'(s * 32), 2'(s), 64'h1122_3344_5566_7788, "R12 size code");

        // Error rejection and interrupt
        cfg_reject_err = 1'b1;
        send(1'b0, 32'h9000_0200, 2'd2, '0, "R5 error reject");
        check("R5 irq set", irq, 1'b1);
        send(1'b0, 32'h0000_0080, 2'd2, '0, "R7 later forward");
        check("R7 irq sticky", irq, 1'b1);
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk);
        check("R6 irq cleared", irq, 1'b0);
        send(1'b1, 32'hB000_0000, 2'd3, '0, "R6 reject during clear");
        check("R6 irq held low", irq, 1'b0);
        @(negedge clk); irq_clr = 1'b0;
        @(negedge clk);
        check("R6 irq low after clear", irq, 1'b0);

        // Configuration change right after acceptance
        cfg_master_ns = 1'b0;
        fork
            send(1'b0, 32'h9000_0300, 2'd3, '0, "R10 cfg sampled at accept");
            begin
                @(negedge clk);
                while (up_req_ready) @(negedge clk);
                cfg_master_ns = 1'b1;
            end
        join
        check("R10 no irq", irq, 1'b0);

        repeat (4) @(negedge clk);
        check("R4 downstream queue drained", 64'(dn_q.size()), 64'd0);
        finish_run();
    end
endmodule